// File: doc/BRIEF.md
# Bus Clock Phase and Refresh Scheduler

This block divides a fast master clock into bus cycles. Each bus cycle has a phase-one half followed by a phase-two half. The block drives two non-overlapping processor clock phases from these halves. It also drives a free-running memory clock and an active-low refresh strobe.

The bus cycles are grouped into a repeating frame. A fixed set of frame slots are taken for dynamic-memory refresh. In a taken slot, the processor clock stays in phase one for the whole cycle and phase two is held low. Anything clocked by phase two therefore sees an idle cycle, while the memory clock keeps toggling. The strobe starts a fixed number of master clocks into phase one of a refresh cycle and stays low for one full bus cycle. A row counter gives the memory array the row to refresh and steps once per refresh cycle.

The processor takes its clocks from the two phase outputs. Dynamic memory takes its clock from the free-running output and its row address from the row counter. All outputs are registered on the master clock.

Top module: `clk_refresh_sched`

## Requirements
- R1: On a rising edge with `rst_n` low, the outputs become phi1=1, phi2=0, phi0=0, ref_n=1 and row=0. The scheduler then sits at clock 0 of a normal bus cycle at frame position 1.
- R2: Every bus cycle lasts 14 master clocks. The first 7 clocks (positions 0 to 6) are phase one and the last 7 (positions 7 to 13) are phase two.
- R3: phi1 and phi2 are never high together.
- R4: A frame is 65 bus cycles, numbered 0 to 64. The cycles at positions 0, 16, 32 and 48 are refresh cycles. After reset, the first refresh cycle is the 16th bus cycle (position 16).
- R5: In a refresh cycle, phi2 stays low and phi1 stays high for all 14 clocks. In every other cycle, phi1 is high exactly in phase one and phi2 is high exactly in phase two.
- R6: phi0 is high in phase two of every bus cycle, refresh cycles included, and low in phase one.
- R7: ref_n goes low at clock 2 of a refresh cycle and stays low for exactly 14 master clocks. It returns high at clock 2 of the following cycle.
- R8: row increments by one at the first clock of the cycle that follows each refresh cycle, wrapping from 127 to 0. It does not change at any other time.
- R9: Over any 65 consecutive bus cycles, ref_n has exactly 4 falling edges, phi2 exactly 61 rising edges, and phi0 exactly 65 rising edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, 14 ticks per bus cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| phi0 | output | 1 | Free-running memory clock, high in phase two |
| phi1 | output | 1 | Processor phase one, stretched through refresh cycles |
| phi2 | output | 1 | Processor phase two, suppressed in refresh cycles |
| ref_n | output | 1 | Active-low refresh strobe |
| row | output | 7 | Refresh row address |

## Verification
Each output is registered from the next-state decode of the position counters. As a result, after k rising edges past the release of reset, the outputs already show bus cycle k/14 at clock k mod 14, with no extra lag. The row counter shows its new value at the same edge that starts the cycle after a refresh. The bench places every sample at the falling edge after exactly 14·c + t rising edges, so each vector lands on a known (cycle, clock) pair. It checks frame-wide edge counts and the 127-to-0 row wrap by watching every falling edge across the whole window.

// File: rtl/clkref_pkg.sv
// Package: shared types and helpers for the clock phase and refresh scheduler.
// Assumes: callers pass non-negative frame positions.
package clkref_pkg;

    // Registered clock outputs, grouped for one assignment.
    typedef struct packed {
        logic phi0;
        logic phi1;
        logic phi2;
        logic ref_n;
    } clk_outs_t;

    // True when a frame position is one of the stolen refresh slots.
    function automatic logic is_refresh_slot(input int pos, input int spacing, input int count);
        return ((pos % spacing) == 0) && (pos < spacing * count);
    endfunction

endpackage

// File: rtl/bus_cycle_ticker.sv
// Module: bus_cycle_ticker
// Counts master clocks within one bus cycle and flags the last one.
// Assumes: PH1 and PH2 are both at least 1.
module bus_cycle_ticker #(
    parameter int PH1 = 7,
    parameter int PH2 = 7,
    localparam int TOTAL = PH1 + PH2,
    localparam int TW = $clog2(TOTAL)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [TW-1:0] tick_nxt,
    output logic          last
);

    logic [TW-1:0] tick_q;

    // Decode the final clock of the bus cycle and the following position.
    always_comb begin
        last     = (tick_q == TW'(TOTAL - 1));
        tick_nxt = last ? '0 : tick_q + 1'b1;
    end

    // Advance the position each master clock; reset to clock 0.
    always_ff @(posedge clk) begin
        if (!rst_n) tick_q <= '0;
        else        tick_q <= tick_nxt;
    end

    p_tick_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(tick_q) < TOTAL);

endmodule

// File: rtl/frame_slot_sched.sv
// Module: frame_slot_sched
// Tracks the bus cycle position within the refresh frame and reports
// whether the coming cycle is a refresh cycle or follows one.
// Assumes: adv pulses once per bus cycle on its last clock.
module frame_slot_sched
    import clkref_pkg::*;
#(
    parameter int FRAME_LEN = 65,
    parameter int SPACING   = 16,
    parameter int SLOTS     = 4,
    parameter int START_POS = 1,
    localparam int FW = $clog2(FRAME_LEN)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    output logic refresh_nxt,
    output logic tail_nxt,
    output logic refresh_done
);

    logic [FW-1:0] frame_q, frame_nxt;
    logic          tail_q;
    logic          slot_now;

    // Classify the current and next frame positions.
    always_comb begin
        slot_now     = is_refresh_slot(int'(frame_q), SPACING, SLOTS);
        frame_nxt    = !adv ? frame_q :
                       (frame_q == FW'(FRAME_LEN - 1)) ? '0 : frame_q + 1'b1;
        refresh_nxt  = is_refresh_slot(int'(frame_nxt), SPACING, SLOTS);
        tail_nxt     = adv ? slot_now : tail_q;
        refresh_done = adv && slot_now;
    end

    // Hold the frame position and the previous-cycle refresh flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= FW'(START_POS);
            tail_q  <= 1'b0;
        end else begin
            frame_q <= frame_nxt;
            tail_q  <= tail_nxt;
        end
    end

    p_frame_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(frame_q) < FRAME_LEN);
    p_tail_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_done |=> tail_q);

endmodule

// File: rtl/refresh_row_counter.sv
// Module: refresh_row_counter
// Holds the row address for memory refresh; steps once per refresh.
// Assumes: inc is a single-clock pulse.
module refresh_row_counter #(
    parameter int RW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    output logic [RW-1:0] row
);

    // Count completed refresh cycles, wrapping at the counter width.
    always_ff @(posedge clk) begin
        if (!rst_n)   row <= '0;
        else if (inc) row <= row + 1'b1;
    end

    p_row_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (row != $past(row)) |-> (row == RW'($past(row) + 1'b1)));

endmodule

// File: rtl/phase_out_gen.sv
// Module: phase_out_gen
// Registers the processor phases, the memory clock and the refresh strobe
// from the next-state cycle position, so outputs line up with the counters.
// Assumes: STROBE_OFS lies inside phase one.
module phase_out_gen
    import clkref_pkg::*;
#(
    parameter int PH1        = 7,
    parameter int STROBE_OFS = 2,
    parameter int TW         = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] tick_nxt,
    input  logic          refresh_nxt,
    input  logic          tail_nxt,
    output clk_outs_t     outs
);

    clk_outs_t d;
    logic      in_ph1;

    // Decode the outputs for the coming master clock.
    always_comb begin
        in_ph1  = int'(tick_nxt) < PH1;
        d.phi1  = in_ph1 || refresh_nxt;
        d.phi2  = !in_ph1 && !refresh_nxt;
        d.phi0  = !in_ph1;
        d.ref_n = !((refresh_nxt && int'(tick_nxt) >= STROBE_OFS) ||
                    (tail_nxt && int'(tick_nxt) < STROBE_OFS));
    end

    // Register the outputs; reset parks in phase one with the strobe idle.
    always_ff @(posedge clk) begin
        if (!rst_n) outs <= '{phi0: 1'b0, phi1: 1'b1, phi2: 1'b0, ref_n: 1'b1};
        else        outs <= d;
    end

    p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(outs.phi1 && outs.phi2));
    p_phi2_needs_phi0_r6: assert property (@(posedge clk) disable iff (!rst_n)
        outs.phi2 |-> outs.phi0);
    p_strobe_blocks_phi2_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !outs.ref_n |-> !outs.phi2);

endmodule

// File: rtl/clk_refresh_sched.sv
// Module: clk_refresh_sched (top)
// Derives two processor clock phases, a free-running memory clock, a refresh
// strobe and a refresh row address from a master clock. It steals
// SLOT_COUNT of every FRAME_CYCLES bus cycles for refresh.
// Assumes: a free-running master clock; synchronous active-low reset.
module clk_refresh_sched
    import clkref_pkg::*;
#(
    parameter int PH1_TICKS    = 7,
    parameter int PH2_TICKS    = 7,
    parameter int STROBE_DELAY = 2,
    parameter int FRAME_CYCLES = 65,
    parameter int SLOT_SPACING = 16,
    parameter int SLOT_COUNT   = 4,
    parameter int START_POS    = 1,
    parameter int ROW_W        = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             phi0,
    output logic             phi1,
    output logic             phi2,
    output logic             ref_n,
    output logic [ROW_W-1:0] row
);

    localparam int TW = $clog2(PH1_TICKS + PH2_TICKS);

    logic [TW-1:0] tick_nxt;
    logic          last_tick;
    logic          refresh_nxt, tail_nxt, refresh_done;
    clk_outs_t     outs;

    bus_cycle_ticker #(.PH1(PH1_TICKS), .PH2(PH2_TICKS)) u_ticker (
        .clk(clk), .rst_n(rst_n), .tick_nxt(tick_nxt), .last(last_tick)
    );

    frame_slot_sched #(
        .FRAME_LEN(FRAME_CYCLES), .SPACING(SLOT_SPACING),
        .SLOTS(SLOT_COUNT), .START_POS(START_POS)
    ) u_frame (
        .clk(clk), .rst_n(rst_n), .adv(last_tick),
        .refresh_nxt(refresh_nxt), .tail_nxt(tail_nxt),
        .refresh_done(refresh_done)
    );

    refresh_row_counter #(.RW(ROW_W)) u_row (
        .clk(clk), .rst_n(rst_n), .inc(refresh_done), .row(row)
    );

    phase_out_gen #(.PH1(PH1_TICKS), .STROBE_OFS(STROBE_DELAY), .TW(TW)) u_phase (
        .clk(clk), .rst_n(rst_n), .tick_nxt(tick_nxt),
        .refresh_nxt(refresh_nxt), .tail_nxt(tail_nxt), .outs(outs)
    );

    // Break the output bundle out onto the ports.
    always_comb begin
        phi0  = outs.phi0;
        phi1  = outs.phi1;
        phi2  = outs.phi2;
        ref_n = outs.ref_n;
    end

endmodule

// File: tb/clk_refresh_sched_test.sv
module clk_refresh_sched_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       phi0, phi1, phi2, ref_n;
    logic [6:0] row;

    int checks = 0;
    int errors = 0;
    int pos    = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    clk_refresh_sched uut (
        .clk(clk), .rst_n(rst_n), .phi0(phi0), .phi1(phi1),
        .phi2(phi2), .ref_n(ref_n), .row(row)
    );

    // Vector: {bus cycle since reset[7:0], clock[3:0], phi1,phi2,phi0,ref_n, row[6:0]}
    localparam int NV = 18;
    localparam logic [22:0] VEC [NV] = '{
        {8'd0,  4'd0,  4'b1001, 7'd0},
        {8'd0,  4'd6,  4'b1001, 7'd0},
        {8'd0,  4'd7,  4'b0111, 7'd0},
        {8'd0,  4'd13, 4'b0111, 7'd0},
        {8'd15, 4'd1,  4'b1001, 7'd0},
        {8'd15, 4'd2,  4'b1000, 7'd0},
        {8'd15, 4'd7,  4'b1010, 7'd0},
        {8'd15, 4'd13, 4'b1010, 7'd0},
        {8'd16, 4'd0,  4'b1000, 7'd1},
        {8'd16, 4'd1,  4'b1000, 7'd1},
        {8'd16, 4'd2,  4'b1001, 7'd1},
        {8'd16, 4'd7,  4'b0111, 7'd1},
        {8'd31, 4'd9,  4'b1010, 7'd1},
        {8'd32, 4'd3,  4'b1001, 7'd2},
        {8'd63, 4'd10, 4'b0111, 7'd3},
        {8'd64, 4'd5,  4'b1000, 7'd3},
        {8'd65, 4'd0,  4'b1000, 7'd4},
        {8'd80, 4'd4,  4'b1000, 7'd4}
    };

    task automatic chk(input string tag, input logic [10:0] act, input logic [10:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got phi1/phi2/phi0/ref_n=%b row=%0d, expected %b row=%0d",
                     tag, act[10:7], act[6:0], exp[10:7], exp[6:0]);
        end
    endtask

    task automatic chk_int(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d, expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [10:0] now_outs();
        return {phi1, phi2, phi0, ref_n, row};
    endfunction

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got %0d cycles, expected under 150000", cycles);
            finish_run();
        end
    end

    initial begin
        int p2_rise, p0_rise, rn_fall, rn_low, steps;
        logic lp2, lp0, lrn;
        logic [6:0] lrow;
        bit wrapped;

        // R1: reset state held while rst_n is low
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", now_outs(), {4'b1001, 7'd0});
        rst_n = 1'b1;
        pos = 0;

        // Vector walk: R2, R4, R5, R6, R7, R8 at fixed (cycle, clock) points
        for (int i = 0; i < NV; i++) begin
            int target;
            target = int'(VEC[i][22:15]) * 14 + int'(VEC[i][14:11]);
            repeat (target - pos) @(negedge clk);
            pos = target;
            chk($sformatf("R2 R4 R5 R6 R7 R8 vector %0d", i), now_outs(), VEC[i][10:0]);
        end

        // R9 and R7: one full frame, from clock 2 of bus cycle 130
        repeat (130 * 14 + 2 - pos) @(negedge clk);
        pos = 130 * 14 + 2;
        lp2 = phi2; lp0 = phi0; lrn = ref_n;
        p2_rise = 0; p0_rise = 0; rn_fall = 0; rn_low = 0;
        for (int k = 0; k < 65 * 14; k++) begin
            if (!ref_n) rn_low++;
            @(negedge clk);
            pos++;
            if (phi2 && !lp2) p2_rise++;
            if (phi0 && !lp0) p0_rise++;
            if (!ref_n && lrn) rn_fall++;
            lp2 = phi2; lp0 = phi0; lrn = ref_n;
        end
        chk_int("R9 strobe falls per frame", rn_fall, 4);
        chk_int("R9 phi2 pulses per frame", p2_rise, 61);
        chk_int("R9 phi0 pulses per frame", p0_rise, 65);
        chk_int("R7 strobe low clocks per frame", rn_low, 56);

        // R8: row steps by one and wraps from 127 to 0
        lrow = row; wrapped = 0; steps = 0;
        for (int k = 0; k < 40000 && !wrapped; k++) begin
            @(negedge clk);
            if (row != lrow) begin
                if (row != 7'(lrow + 7'd1)) steps++;
                if (lrow == 7'd127 && row == 7'd0) wrapped = 1;
                lrow = row;
            end
        end
        chk_int("R8 row wrap 127 to 0 seen", int'(wrapped), 1);
        chk_int("R8 row step errors", steps, 0);

        // R1: reset in mid-run returns to the reset state
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid-run reset outputs", now_outs(), {4'b1001, 7'd0});
        rst_n = 1'b1;
        repeat (7) @(negedge clk);
        chk("R2 R1 phase two after restart", now_outs(), {4'b0111, 7'd0});
        repeat (15 * 14 + 2 - 7) @(negedge clk);
        chk("R4 R7 first refresh after restart", now_outs(), {4'b1000, 7'd0});

        finish_run();
    end

endmodule